// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block turns a decoded operand specifier into an operand value and its effective address. A request carries a 4-bit mode code, a 16-bit address field, a 3-bit register selector and a 2-bit indirection depth. The block holds an 8-entry register file and takes the current program counter as an input. It then issues the memory reads that the selected mode calls for, one at a time, on a synchronous read port whose data arrives in the cycle after the request.

A sequencer walks through pointer reads and the final operand read. The datapath forms addresses with modulo-2^16 adders. Pointer chains and the two combined index orderings are handled by repeating the pointer-read step. The indexed auto-increment mode writes the bumped register back in the cycle in which the result is reported. Register entry 7 acts as the stack pointer.

Top module: `opnd_addr_gen`

## Requirements
- R1: After reset, busy, done, memReq and illegalMode are low, and operand and effAddr read 0.
- R2: Mode 0 (immediate) reports operand = effAddr = address field, issues no memory read, and raises done in the first cycle after acceptance.
- R3: Mode 1 (direct) reports effAddr = address field and operand = memory word at that address, using exactly one read.
- R4: Mode 2 (indirect) follows a pointer chain starting at the address field. The level input gives the number of pointer reads: 1, 2 or 3, with code 0 treated as 1. One further read fetches the operand, and effAddr is the last pointer.
- R5: Mode 3 (register) reports operand = register[sel] and effAddr = sel zero-extended, with no memory read.
- R6: Mode 4 (register indirect) uses effAddr = register[sel] and takes one read.
- R7: Mode 5 (displacement) uses effAddr = field + register[sel]. Mode 6 (PC-relative) uses effAddr = field + pcValue. Both wrap modulo 2^16 and take one read.
- R8: Mode 7 (indexed) uses effAddr = field + register[sel] and takes one read. In the done cycle it writes register[sel] + 1 (wrapping) back to register[sel].
- R9: Mode 8 (pre-index) reads the pointer at field + register[sel] and uses that word as effAddr. It takes two reads in total.
- R10: Mode 9 (post-index) reads the pointer at the field and uses pointer + register[sel] as effAddr. It takes two reads in total.
- R11: Mode 10 (stack) uses effAddr = register[7] and takes one read. The field and selector are ignored.
- R12: Codes 11 to 15 raise illegalMode together with done, issue no read, and report operand = effAddr = 0.
- R13: Done is a one-cycle pulse that comes 1 + 2×(number of reads) cycles after acceptance. Each memReq lasts one cycle. A request offered while busy is ignored.
- R14: A register-file write made while idle is seen by the next request that reads that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered; taken only when idle |
| reqMode | input | 4 | Addressing mode code |
| reqField | input | 16 | Address/immediate field |
| reqReg | input | 3 | Register selector |
| reqLevels | input | 2 | Pointer-chain depth for mode 2 |
| pcValue | input | 16 | Current program counter |
| rfWrEn | input | 1 | Register-file write enable |
| rfWrAddr | input | 3 | Register-file write index |
| rfWrData | input | 16 | Register-file write data |
| memReq | output | 1 | Memory read strobe |
| memAddr | output | 16 | Memory read address |
| memData | input | 16 | Read data, valid the cycle after memReq |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| operand | output | 16 | Operand value |
| effAddr | output | 16 | Effective address |
| illegalMode | output | 1 | Unknown mode code flag |

## Verification
Every memory access takes two cycles: one to issue the request and one to capture the data. The result is therefore due 1 + 2×reads cycles after the accepting edge. That is one cycle for the immediate, register and illegal modes, three for single-read modes, five for pre-index, post-index and single-level indirection, and up to nine for a three-level chain. The bench counts falling edges from acceptance until done and compares that count with the expected value. It samples operand, effAddr and illegalMode on that falling edge. It also checks that done has dropped one edge later. The number of read strobes is counted separately at the memory model, and the auto-increment write-back is checked by a later register-mode request.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

  typedef enum logic [3:0] {
    MODE_IMM    = 4'd0,
    MODE_DIRECT = 4'd1,
    MODE_INDIR  = 4'd2,
    MODE_REG    = 4'd3,
    MODE_REGIND = 4'd4,
    MODE_DISP   = 4'd5,
    MODE_REL    = 4'd6,
    MODE_IDXINC = 4'd7,
    MODE_PRE    = 4'd8,
    MODE_POST   = 4'd9,
    MODE_STACK  = 4'd10
  } addrMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREQ,
    ST_PWAIT,
    ST_OREQ,
    ST_OWAIT,
    ST_FIN
  } seqState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;       // capture a new request
    logic memReq;     // drive a read at the held address
    logic capPtr;     // held address <= read word (+ index)
    logic ptrAddIdx;  // add latched register value on capPtr
    logic capOpnd;    // operand <= read word
    logic incWb;      // write back register + 1
  } seqStrobes_t;

endpackage

// File: rtl/opnd_addr_ctrl.sv
module opnd_addr_ctrl
  import opnd_addr_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [3:0]       reqMode,
  input  logic [LVL_W-1:0] reqLevels,
  output seqStrobes_t      strb,
  output logic             busy,
  output logic             done,
  output logic             illegalMode
);

  seqState_e        st, stNext;
  logic [3:0]       modeReg;
  logic [LVL_W-1:0] lvlLeft;
  logic [LVL_W-1:0] lvlStart;
  logic             illegalReg;

  assign lvlStart = (reqMode == MODE_INDIR && reqLevels != '0) ? reqLevels : LVL_W'(1);

  always_comb begin
    stNext = st;
    strb   = '0;
    case (st)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          case (reqMode)
            MODE_IMM, MODE_REG:              stNext = ST_FIN;
            MODE_INDIR, MODE_PRE, MODE_POST: stNext = ST_PREQ;
            MODE_DIRECT, MODE_REGIND, MODE_DISP, MODE_REL,
            MODE_IDXINC, MODE_STACK:         stNext = ST_OREQ;
            default:                         stNext = ST_FIN;
          endcase
        end
      end
      ST_PREQ: begin
        strb.memReq = 1'b1;
        stNext      = ST_PWAIT;
      end
      ST_PWAIT: begin
        strb.capPtr    = 1'b1;
        strb.ptrAddIdx = (modeReg == MODE_POST);
        stNext         = (lvlLeft == LVL_W'(1)) ? ST_OREQ : ST_PREQ;
      end
      ST_OREQ: begin
        strb.memReq = 1'b1;
        stNext      = ST_OWAIT;
      end
      ST_OWAIT: begin
        strb.capOpnd = 1'b1;
        stNext       = ST_FIN;
      end
      ST_FIN: begin
        strb.incWb = (modeReg == MODE_IDXINC);
        stNext     = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      modeReg    <= '0;
      lvlLeft    <= '0;
      illegalReg <= 1'b0;
    end else begin
      st <= stNext;
      if (strb.load) begin
        modeReg    <= reqMode;
        lvlLeft    <= lvlStart;
        illegalReg <= (reqMode > MODE_STACK);
      end else if (strb.capPtr) begin
        lvlLeft <= lvlLeft - LVL_W'(1);
      end
    end
  end

  assign busy        = (st != ST_IDLE);
  assign done        = (st == ST_FIN);
  assign illegalMode = illegalReg;

endmodule

// File: rtl/opnd_addr_dp.sv
module opnd_addr_dp
  import opnd_addr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int REG_W  = $clog2(REG_CNT),
  localparam int SP_IDX = REG_CNT - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [3:0]        reqMode,
  input  logic [DATA_W-1:0] reqField,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [DATA_W-1:0] pcValue,
  input  logic              rfWrEn,
  input  logic [REG_W-1:0]  rfWrAddr,
  input  logic [DATA_W-1:0] rfWrData,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] operand
);

  logic [DATA_W-1:0] rf [REG_CNT];
  logic [DATA_W-1:0] selVal;
  logic [DATA_W-1:0] idxVal;
  logic [REG_W-1:0]  idxReg;
  logic [DATA_W-1:0] addrReg, opReg;
  logic [DATA_W-1:0] addrInit, opInit;
  logic [DATA_W-1:0] fieldPlusReg;

  assign selVal       = rf[reqReg];
  assign fieldPlusReg = reqField + selVal;

  always_comb begin
    addrInit = '0;
    opInit   = '0;
    case (reqMode)
      MODE_IMM: begin
        addrInit = reqField;
        opInit   = reqField;
      end
      MODE_REG: begin
        addrInit = DATA_W'(reqReg);
        opInit   = selVal;
      end
      MODE_DIRECT, MODE_INDIR, MODE_POST: addrInit = reqField;
      MODE_REGIND:                        addrInit = selVal;
      MODE_DISP, MODE_IDXINC, MODE_PRE:   addrInit = fieldPlusReg;
      MODE_REL:                           addrInit = reqField + pcValue;
      MODE_STACK:                         addrInit = rf[SP_IDX];
      default: begin
        addrInit = '0;
        opInit   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      opReg   <= '0;
      idxReg  <= '0;
      idxVal  <= '0;
    end else begin
      if (strb.load) begin
        addrReg <= addrInit;
        opReg   <= opInit;
        idxReg  <= reqReg;
        idxVal  <= selVal;
      end else if (strb.capPtr) begin
        addrReg <= memData + (strb.ptrAddIdx ? idxVal : '0);
      end else if (strb.capOpnd) begin
        opReg <= memData;
      end
    end
  end

  // register file: auto-increment write-back wins over the external port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) rf[i] <= '0;
    end else begin
      for (int i = 0; i < REG_CNT; i++) begin
        if (strb.incWb && idxReg == REG_W'(i))
          rf[i] <= rf[i] + DATA_W'(1);
        else if (rfWrEn && rfWrAddr == REG_W'(i))
          rf[i] <= rfWrData;
      end
    end
  end

  assign memAddr = addrReg;
  assign effAddr = addrReg;
  assign operand = opReg;

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_addr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  parameter int LVL_W   = 2,
  localparam int REG_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqMode,
  input  logic [DATA_W-1:0] reqField,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [LVL_W-1:0]  reqLevels,
  input  logic [DATA_W-1:0] pcValue,
  input  logic              rfWrEn,
  input  logic [REG_W-1:0]  rfWrAddr,
  input  logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] effAddr,
  output logic              illegalMode
);

  seqStrobes_t strb;

  opnd_addr_ctrl #(.LVL_W(LVL_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqMode     (reqMode),
    .reqLevels   (reqLevels),
    .strb        (strb),
    .busy        (busy),
    .done        (done),
    .illegalMode (illegalMode)
  );

  opnd_addr_dp #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqMode  (reqMode),
    .reqField (reqField),
    .reqReg   (reqReg),
    .pcValue  (pcValue),
    .rfWrEn   (rfWrEn),
    .rfWrAddr (rfWrAddr),
    .rfWrData (rfWrData),
    .memData  (memData),
    .memAddr  (memAddr),
    .effAddr  (effAddr),
    .operand  (operand)
  );

  assign memReq = strb.memReq;

endmodule

// File: rtl/opnd_addr_chk.sv
module opnd_addr_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [3:0]        reqMode,
  input logic [DATA_W-1:0] reqField,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic [DATA_W-1:0] effAddr,
  input logic [DATA_W-1:0] operand,
  input logic              illegalMode
);

  logic [3:0]        capMode;
  logic [DATA_W-1:0] capField;
  logic [2:0]        rdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capMode  <= '0;
      capField <= '0;
      rdCnt    <= '0;
    end else if (reqValid && !busy) begin
      capMode  <= reqMode;
      capField <= reqField;
      rdCnt    <= '0;
    end else if (memReq) begin
      rdCnt <= rdCnt + 3'd1;
    end
  end

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_idle_after_done_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_single_read_strobe_r13: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  p_imm_no_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && capMode == 4'd0) |-> (rdCnt == 3'd0 && operand == capField && effAddr == capField));
  p_direct_one_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && capMode == 4'd1) |-> (rdCnt == 3'd1 && effAddr == capField));
  p_reg_no_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && capMode == 4'd3) |-> rdCnt == 3'd0);
  p_stack_one_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && capMode == 4'd10) |-> rdCnt == 3'd1);
  p_index_two_reads_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && (capMode == 4'd8 || capMode == 4'd9)) |-> rdCnt == 3'd2);
  p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegalMode) |-> (rdCnt == 3'd0 && effAddr == '0 && operand == '0));

endmodule

bind opnd_addr_gen opnd_addr_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqMode     (reqMode),
  .reqField    (reqField),
  .busy        (busy),
  .done        (done),
  .memReq      (memReq),
  .effAddr     (effAddr),
  .operand     (operand),
  .illegalMode (illegalMode)
);

// File: tb/test_opnd_addr_gen.sv
module test_opnd_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PC_VAL = 16'h0300;

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] field;
    logic [2:0]  sel;
    logic [1:0]  lv;
    logic [2:0]  reads;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  16'h1234, 3'd0, 2'd0, 3'd0},  // R2
    '{4'd1,  16'h0040, 3'd0, 2'd0, 3'd1},  // R3
    '{4'd2,  16'h0041, 3'd0, 2'd0, 3'd2},  // R4 code 0 -> one level
    '{4'd2,  16'h0042, 3'd0, 2'd1, 3'd2},  // R4
    '{4'd2,  16'h0043, 3'd0, 2'd2, 3'd3},  // R4
    '{4'd2,  16'h0044, 3'd0, 2'd3, 3'd4},  // R4
    '{4'd3,  16'h7777, 3'd3, 2'd0, 3'd0},  // R5, R14
    '{4'd4,  16'h0000, 3'd2, 2'd0, 3'd1},  // R6
    '{4'd5,  16'h0005, 3'd4, 2'd0, 3'd1},  // R7
    '{4'd5,  16'hFFF0, 3'd5, 2'd0, 3'd1},  // R7 wrap
    '{4'd6,  16'h0020, 3'd1, 2'd0, 3'd1},  // R7 relative
    '{4'd7,  16'h0010, 3'd6, 2'd0, 3'd1},  // R8
    '{4'd7,  16'h0010, 3'd6, 2'd0, 3'd1},  // R8 uses bumped index
    '{4'd3,  16'h0000, 3'd6, 2'd0, 3'd0},  // R8 write-back visible
    '{4'd8,  16'h0003, 3'd1, 2'd0, 3'd2},  // R9
    '{4'd9,  16'h0050, 3'd1, 2'd0, 3'd2},  // R10
    '{4'd10, 16'h9999, 3'd2, 2'd3, 3'd1},  // R11
    '{4'd11, 16'h0040, 3'd1, 2'd0, 3'd0},  // R12
    '{4'd15, 16'hFFFF, 3'd7, 2'd0, 3'd0},  // R12
    '{4'd3,  16'h0000, 3'd0, 2'd0, 3'd0}   // R5 register 0
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqMode = '0;
  logic [15:0] reqField = '0;
  logic [2:0]  reqReg = '0;
  logic [1:0]  reqLevels = '0;
  logic        rfWrEn = 1'b0;
  logic [2:0]  rfWrAddr = '0;
  logic [15:0] rfWrData = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic [15:0] memData = '0;
  logic        busy, done, illegalMode;
  logic [15:0] operand, effAddr;

  logic [15:0] memArr [256];
  logic [15:0] shReg [8];
  int          readsTotal = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_gen i_opnd_addr_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqField(reqField), .reqReg(reqReg), .reqLevels(reqLevels),
    .pcValue(PC_VAL), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .busy(busy),
    .done(done), .operand(operand), .effAddr(effAddr), .illegalMode(illegalMode)
  );

  // memory model: data one cycle after the strobe
  always @(posedge clk) begin
    if (memReq) begin
      memData    <= memArr[memAddr[7:0]];
      readsTotal <= readsTotal + 1;
    end
  end

  function automatic logic [15:0] rdMem(input logic [15:0] a);
    return memArr[a[7:0]];
  endfunction

  function automatic string tagOf(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5, 4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      4'd10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] idx, input logic [15:0] val);
    @(negedge clk);
    rfWrEn = 1'b1; rfWrAddr = idx; rfWrData = val;
    @(negedge clk);
    rfWrEn = 1'b0;
    shReg[idx] = val;
  endtask

  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runReq(input vec_t v);
    logic [15:0] expEa, expOp, p;
    bit          expIll;
    int          lat, startReads, nPtr;
    string       tag;
    tag    = tagOf(v.mode);
    expIll = 1'b0;
    expOp  = '0;
    case (v.mode)
      4'd0: begin expEa = v.field; expOp = v.field; end
      4'd1: expEa = v.field;
      4'd2: begin
        nPtr = (v.lv == 2'd0) ? 1 : int'(v.lv);
        p = v.field;
        for (int k = 0; k < nPtr; k++) p = rdMem(p);
        expEa = p;
      end
      4'd3: begin expEa = {13'd0, v.sel}; expOp = shReg[v.sel]; end
      4'd4: expEa = shReg[v.sel];
      4'd5, 4'd7: expEa = v.field + shReg[v.sel];
      4'd6: expEa = v.field + PC_VAL;
      4'd8: expEa = rdMem(v.field + shReg[v.sel]);
      4'd9: expEa = rdMem(v.field) + shReg[v.sel];
      4'd10: expEa = shReg[7];
      default: begin expEa = '0; expIll = 1'b1; end
    endcase
    if (v.mode != 4'd0 && v.mode != 4'd3 && !expIll) expOp = rdMem(expEa);

    @(negedge clk);
    startReads = readsTotal;
    reqValid = 1'b1; reqMode = v.mode; reqField = v.field;
    reqReg = v.sel; reqLevels = v.lv;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(lat);
    chk(done == 1'b1, tag, "done seen", int'(done), 1);
    chk(lat == 1 + 2 * int'(v.reads), "R13", "latency", lat, 1 + 2 * int'(v.reads));
    chk(readsTotal - startReads == int'(v.reads), tag, "read count",
        readsTotal - startReads, int'(v.reads));
    chk(effAddr == expEa, tag, "effAddr", int'(effAddr), int'(expEa));
    chk(operand == expOp, tag, "operand", int'(operand), int'(expOp));
    chk(illegalMode == expIll, tag, "illegalMode", int'(illegalMode), int'(expIll));
    if (v.mode == 4'd7) shReg[v.sel] = shReg[v.sel] + 16'd1;
    @(negedge clk);
    chk(done == 1'b0, "R13", "done pulse width", int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int lat, startReads;
    for (int i = 0; i < 256; i++)
      memArr[i] = {8'(i) ^ 8'h3C, 8'(i) + 8'h11};
    for (int i = 0; i < 8; i++) shReg[i] = '0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(memReq == 1'b0, "R1", "memReq", int'(memReq), 0);
    chk(illegalMode == 1'b0, "R1", "illegalMode", int'(illegalMode), 0);
    chk(operand == 16'h0 && effAddr == 16'h0, "R1", "operand|effAddr",
        int'({operand, effAddr}), 0);
    rstN = 1'b1;

    // R14: load register file through the write port
    wrReg(3'd1, 16'h0011);
    wrReg(3'd2, 16'h0062);
    wrReg(3'd3, 16'hA5C3);
    wrReg(3'd4, 16'h0100);
    wrReg(3'd5, 16'h0123);
    wrReg(3'd6, 16'hFFFF);
    wrReg(3'd7, 16'h00A0);

    for (int n = 0; n < NVEC; n++) runReq(VECS[n]);

    // R13: request offered while busy is ignored
    @(negedge clk);
    startReads = readsTotal;
    reqValid = 1'b1; reqMode = 4'd1; reqField = 16'h0077; reqReg = 3'd0; reqLevels = 2'd0;
    @(negedge clk);
    reqMode = 4'd0; reqField = 16'hBEEF;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 3, "R13", "latency with busy request", lat, 3);
    chk(operand == rdMem(16'h0077), "R13", "operand not replaced",
        int'(operand), int'(rdMem(16'h0077)));
    chk(effAddr == 16'h0077, "R13", "effAddr not replaced", int'(effAddr), 16'h0077);
    repeat (4) begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R13", "no late acceptance",
          int'({busy, done}), 0);
    end
    chk(readsTotal - startReads == 1, "R13", "reads with busy request",
        readsTotal - startReads, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule